// File: doc/BRIEF.md
# Atomic Swap and Compare-Swap Memory

This block is a single-port, byte-addressable storage array mapped into one address window of a system address space. It serves plain reads and writes, unconditional swaps that return the previous contents while storing new data, and conditional swaps. A conditional swap stores new data only when the current contents equal a supplied compare value. Operands are 1, 2, 4 or 8 bytes, packed little-endian inside 64-bit words. An access may not straddle an 8-byte word.

A requester presents one request per cycle on a valid/ready pair. Each request carries a command, an address, a size code, write data, a compare value, a response-wanted flag and an inhibit flag. The memory action happens in the cycle the request is taken. This makes every read-compare-write atomic. The block then holds `req_ready` low until the response slot, so nothing else can slip between the compare and the write. The response appears a fixed, parameterised number of cycles after acceptance. When the zero-initialisation parameter is set, reset clears every location.

Top module: `atomic_mem`

## Requirements
- R1: A read returns the addressed bytes right-aligned in `rsp_rdata`, little-endian (the byte at the lowest address in bits 7:0), with the unused upper bits zero. The size code is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The command codes are 0=read, 1=write, 2=swap, 3=conditional swap, 4=invalidate.
- R2: A write replaces exactly the addressed bytes with the low bytes of `req_wdata` and leaves the other bytes of the word unchanged. Its response carries `rsp_rdata` equal to the old contents.
- R3: A swap returns the old contents of the addressed bytes and stores the low bytes of `req_wdata` there.
- R4: A conditional swap returns the old contents. It stores `req_wdata` only when those contents equal the low bytes of `req_cmp`, and otherwise leaves memory unchanged.
- R5: A conditional swap with size code 0 or 1 is answered with `rsp_err`=1 and changes no memory.
- R6: A request is answered with `rsp_err`=1 and `rsp_rdata`=0, and changes no memory, in any of these cases: it starts below `BASE_ADDR`; it ends beyond `BASE_ADDR+MEM_BYTES`; it crosses an 8-byte boundary; or it carries a command code above 4.
- R7: A request with `req_inhibit`=1 produces no response and changes no memory.
- R8: A response is a one-cycle `rsp_valid` pulse that appears `LATENCY` clock edges after the accepting edge. `req_ready` is low from the accepting edge until the response edge.
- R9: An invalidate changes no memory. When a response is wanted, it answers with `rsp_rdata`=0 and `rsp_err`=0.
- R10: A request with `req_need_rsp`=0 produces no response but otherwise takes effect.
- R11: After reset, `req_ready`=1 and `rsp_valid`=0. With `ZERO_INIT` set, every byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 3 | Command code (R1) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code, bytes = 1 << code |
| req_wdata | input | 64 | Store data, right-aligned |
| req_cmp | input | 64 | Compare value for conditional swap, right-aligned |
| req_need_rsp | input | 1 | Response wanted |
| req_inhibit | input | 1 | Suppress the access and its response |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Old contents, right-aligned |
| rsp_err | output | 1 | Request rejected |

## Verification
The bound checker watches several rules on every cycle:
- Inhibited, rejected and invalidate requests never raise the array write strobe.
- A short conditional swap is always flagged.
- An error response always carries zero data.
- No write happens while the block is busy.
- `req_ready` drops after each acceptance.
- Every response lands exactly `LATENCY` edges after its acceptance.

Only the bench's scenarios can show the data behaviour against a byte-level model: little-endian lane placement, merging of partial writes, the equal and unequal outcomes of a conditional swap, window-edge rejection, and the absence of responses for inhibited or response-less requests.

// File: rtl/atomic_mem_pkg.sv
package atomic_mem_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = 64;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_SWAP  = 3'd2,
        CMD_CSWAP = 3'd3,
        CMD_INVAL = 3'd4
    } cmd_e;

    typedef struct packed {
        logic                 err;
        logic [WORD_BITS-1:0] data;
    } rsp_t;

    // byte lanes touched by an access of 2**sz bytes at lane off
    function automatic logic [WORD_BYTES-1:0] lane_mask(logic [1:0] sz, logic [2:0] off);
        logic [8:0] m;
        m = (9'd1 << (4'd1 << sz)) - 9'd1;
        return m[7:0] << off;
    endfunction

    function automatic logic [WORD_BITS-1:0] bit_mask(logic [WORD_BYTES-1:0] lanes);
        logic [WORD_BITS-1:0] r;
        for (int b = 0; b < WORD_BYTES; b++) r[b*8 +: 8] = {8{lanes[b]}};
        return r;
    endfunction

    function automatic logic [WORD_BITS-1:0] pick(logic [WORD_BITS-1:0] w, logic [1:0] sz, logic [2:0] off);
        return (w >> {off, 3'b000}) & bit_mask(lane_mask(sz, 3'd0));
    endfunction

endpackage

// File: rtl/atomic_mem_decode.sv
module atomic_mem_decode
    import atomic_mem_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [63:0] BASE_ADDR = 64'h1000,
    parameter int          MEM_BYTES = 256,
    parameter int          IDX_W     = 5
) (
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              err,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        off
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + 64'(MEM_BYTES));

    logic [ADDR_W:0] a_ext, rel;
    logic [3:0]      nbytes;
    logic            in_win, crosses, bad_cmd, short_cas;

    always_comb begin
        a_ext     = {1'b0, addr};
        nbytes    = 4'd1 << size;
        rel       = a_ext - LO;
        off       = rel[2:0];
        idx       = rel[IDX_W+2:3];
        in_win    = (a_ext >= LO) && ((a_ext + (ADDR_W+1)'(nbytes)) <= HI);
        crosses   = ({1'b0, off} + nbytes) > 4'd8;
        bad_cmd   = cmd > CMD_INVAL;
        short_cas = (cmd == CMD_CSWAP) && (size < 2'd2);
        err       = !in_win || crosses || bad_cmd || short_cas;
    end
endmodule

// File: rtl/atomic_mem_array.sv
module atomic_mem_array
    import atomic_mem_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int IDX_W     = 5,
    parameter bit ZERO_INIT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [WORD_BYTES-1:0] lanes,
    input  logic [WORD_BITS-1:0]  wword,
    output logic [WORD_BITS-1:0]  rword
);
    logic [WORD_BITS-1:0] mem [DEPTH];
    logic [WORD_BITS-1:0] merged;

    assign rword = mem[idx];

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign merged[b*8 +: 8] = lanes[b] ? wword[b*8 +: 8] : rword[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (ZERO_INIT && rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= merged;
        end
    end
endmodule

// File: rtl/atomic_mem_resp.sv
module atomic_mem_resp
    import atomic_mem_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic send,
    input  rsp_t rsp_in,
    output logic ready,
    output logic rsp_valid,
    output rsp_t rsp_out
);
    localparam int CW = $clog2(LATENCY + 1);

    logic          busy, hold_send;
    logic [CW-1:0] cnt;
    rsp_t          hold;

    assign ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            hold      <= '0;
            hold_send <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_out   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                busy      <= 1'b1;
                cnt       <= CW'(LATENCY);
                hold      <= rsp_in;
                hold_send <= send;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy      <= 1'b0;
                    rsp_valid <= hold_send;
                    rsp_out   <= hold;
                end
            end
        end
    end
endmodule

// File: rtl/atomic_mem.sv
module atomic_mem
    import atomic_mem_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [63:0] BASE_ADDR = 64'h1000,
    parameter int          MEM_BYTES = 256,
    parameter int          LATENCY   = 3,
    parameter bit          ZERO_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    input  logic [63:0]       req_cmp,
    input  logic              req_need_rsp,
    input  logic              req_inhibit,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int DEPTH = MEM_BYTES / WORD_BYTES;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                  dec_err, accept, mem_we, stores, cmp_eq;
    logic [IDX_W-1:0]      idx;
    logic [2:0]            off;
    logic [WORD_BITS-1:0]  old_word, old_val, cmp_val;
    logic [WORD_BYTES-1:0] lanes;
    rsp_t                  rsp_new, rsp_q;

    atomic_mem_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
                        .MEM_BYTES(MEM_BYTES), .IDX_W(IDX_W)) u_dec (
        .cmd(req_cmd), .addr(req_addr), .size(req_size),
        .err(dec_err), .idx(idx), .off(off)
    );

    always_comb begin
        accept  = req_valid && req_ready;
        lanes   = lane_mask(req_size, off);
        old_val = pick(old_word, req_size, off);
        cmp_val = req_cmp & bit_mask(lane_mask(req_size, 3'd0));
        cmp_eq  = (old_val == cmp_val);
        unique case (req_cmd)
            CMD_WRITE, CMD_SWAP: stores = 1'b1;
            CMD_CSWAP:           stores = cmp_eq;
            default:             stores = 1'b0;
        endcase
        mem_we       = accept && !req_inhibit && !dec_err && stores;
        rsp_new.err  = dec_err;
        rsp_new.data = (dec_err || req_cmd == CMD_INVAL) ? '0 : old_val;
    end

    atomic_mem_array #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ZERO_INIT(ZERO_INIT)) u_arr (
        .clk(clk), .rst(rst), .we(mem_we), .idx(idx), .lanes(lanes),
        .wword(req_wdata << {off, 3'b000}), .rword(old_word)
    );

    atomic_mem_resp #(.LATENCY(LATENCY)) u_rsp (
        .clk(clk), .rst(rst), .accept(accept),
        .send(req_need_rsp && !req_inhibit), .rsp_in(rsp_new),
        .ready(req_ready), .rsp_valid(rsp_valid), .rsp_out(rsp_q)
    );

    assign rsp_rdata = rsp_q.data;
    assign rsp_err   = rsp_q.err;
endmodule

// File: rtl/atomic_mem_chk.sv
module atomic_mem_chk #(
    parameter int LATENCY = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_cmd,
    input logic [1:0]  req_size,
    input logic        req_inhibit,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic        mem_we,
    input logic        dec_err
);
    localparam int AW = $clog2(LATENCY + 3) + 1;

    logic [AW-1:0] age;
    logic          acc;
    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (acc)         age <= AW'(1);
        else if (age != '1)   age <= age + 1'b1;
    end

    p_short_cas_err_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && req_cmd == 3'd3 && req_size < 2'd2) |-> dec_err);
    p_err_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && dec_err) |-> !mem_we);
    p_err_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0));
    p_inhibit_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && req_inhibit) |-> !mem_we);
    p_busy_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !mem_we);
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (age == AW'(LATENCY + 1)));
    p_inval_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        (acc && req_cmd == 3'd4) |-> !mem_we);
    p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid));
endmodule

bind atomic_mem atomic_mem_chk #(.LATENCY(LATENCY)) u_chk (.*);

// File: tb/atomic_mem_test.sv
module atomic_mem_test;
    localparam int          ADDR_W = 32;
    localparam logic [63:0] BASE   = 64'h1000;
    localparam int          MBYTES = 256;
    localparam int          LAT    = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_need_rsp = 0, req_inhibit = 0;
    logic [2:0] req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [63:0] req_wdata = '0, req_cmp = '0;
    logic req_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;

    always #4 clk = ~clk;

    atomic_mem #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .MEM_BYTES(MBYTES),
                 .LATENCY(LAT), .ZERO_INIT(1'b1)) uut (.*);

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] model [MBYTES];
    logic [63:0] q_data[$];
    logic        q_err[$];
    int          q_at[$];
    string       q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_data.size() == 0) begin
                check(0, "R7/R10 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                logic [63:0] d; logic e; int at; string t;
                d = q_data.pop_front(); e = q_err.pop_front();
                at = q_at.pop_front(); t = q_tag.pop_front();
                check(rsp_rdata == d, {t, " data"}, rsp_rdata, d);
                check(rsp_err == e, {t, " err"}, 64'(rsp_err), 64'(e));
                check(cyc == at, "R8 latency", 64'(cyc), 64'(at));
            end
        end
    end

    task automatic req(input logic [2:0] cmd, input longint addr, input logic [1:0] sz,
                       input logic [63:0] wd, input logic [63:0] cp,
                       input bit need, input bit inh, input string tag);
        int n, rel;
        bit err, st;
        logic [63:0] old;
        n   = 1 << sz;
        rel = int'(addr - longint'(BASE));
        err = (cmd > 3'd4) || (addr < longint'(BASE)) ||
              (addr + n > longint'(BASE) + MBYTES) || ((rel % 8) + n > 8) ||
              (cmd == 3'd3 && sz < 2);
        old = '0;
        if (!err) for (int i = 0; i < n; i++) old[i*8 +: 8] = model[rel + i];
        st = 0;
        if (!err && !inh) begin
            if (cmd == 3'd1 || cmd == 3'd2) st = 1;
            if (cmd == 3'd3) st = (old == (cp & ((n == 8) ? '1 : ((64'd1 << (8*n)) - 1))));
        end
        if (st) for (int i = 0; i < n; i++) model[rel + i] = wd[i*8 +: 8];
        while (!req_ready) @(negedge clk);
        if (need && !inh) begin
            q_data.push_back((err || cmd == 3'd4) ? 64'd0 : old);
            q_err.push_back(err);
            q_at.push_back(cyc + 1 + LAT);
            q_tag.push_back(tag);
        end
        req_valid = 1; req_cmd = cmd; req_addr = ADDR_W'(addr); req_size = sz;
        req_wdata = wd; req_cmp = cp; req_need_rsp = need; req_inhibit = inh;
        @(negedge clk);
        req_valid = 0;
        check(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
    endtask

    task automatic rd(input longint addr, input logic [1:0] sz, input string tag);
        req(3'd0, addr, sz, '0, '0, 1, 0, tag);
    endtask

    bit done = 0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MBYTES; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R11 no response after reset", 64'(rsp_valid), 64'd0);
        rd(BASE, 2'd3, "R11 zero init low");
        rd(BASE + MBYTES - 8, 2'd3, "R11 zero init top");
        // R2 / R1
        req(3'd1, BASE, 2'd3, 64'h8877665544332211, '0, 1, 0, "R2 write 8B");
        rd(BASE, 2'd3, "R1 read 8B");
        rd(BASE + 3, 2'd0, "R1 read 1B");
        rd(BASE + 6, 2'd1, "R1 read 2B");
        req(3'd1, BASE + 1, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, '0, 1, 0, "R2 write 1B");
        rd(BASE, 2'd3, "R2 merged word");
        // R3
        req(3'd2, BASE + 4, 2'd2, 64'hDEADBEEF, '0, 1, 0, "R3 swap 4B");
        rd(BASE + 4, 2'd2, "R3 swap stored");
        // R4
        req(3'd3, BASE, 2'd3, 64'h0123456789ABCDEF, 64'd5, 1, 0, "R4 cas mismatch");
        rd(BASE, 2'd3, "R4 unchanged after mismatch");
        req(3'd3, BASE, 2'd3, 64'h0123456789ABCDEF, 64'hDEADBEEF4433AB11, 1, 0, "R4 cas match");
        rd(BASE, 2'd3, "R4 stored after match");
        req(3'd3, BASE + 8, 2'd2, 64'h55AA55AA, 64'hFFFF_FFFF_0000_0000, 1, 0, "R4 cas 4B upper cmp ignored");
        rd(BASE + 8, 2'd3, "R4 4B result");
        // R5
        req(3'd3, BASE + 16, 2'd1, 64'h1234, 64'd0, 1, 0, "R5 cas 2B");
        req(3'd3, BASE + 16, 2'd0, 64'h12, 64'd0, 1, 0, "R5 cas 1B");
        rd(BASE + 16, 2'd3, "R5 unchanged");
        // R6
        req(3'd1, BASE - 8, 2'd3, 64'hAA, '0, 1, 0, "R6 below window");
        req(3'd1, BASE + MBYTES, 2'd0, 64'hAA, '0, 1, 0, "R6 above window");
        req(3'd1, BASE + MBYTES - 4, 2'd3, 64'hAA, '0, 1, 0, "R6 straddles top");
        req(3'd1, BASE + 22, 2'd2, 64'hCAFEF00D, '0, 1, 0, "R6 crosses word");
        req(3'd6, BASE + 16, 2'd3, 64'hAA, '0, 1, 0, "R6 bad command");
        rd(BASE + 16, 2'd3, "R6 word unchanged");
        rd(BASE + MBYTES - 8, 2'd3, "R6 top unchanged");
        // R7
        req(3'd1, BASE + 32, 2'd3, 64'h1111, '0, 1, 1, "R7 inhibited write");
        req(3'd2, BASE, 2'd3, 64'h2222, '0, 1, 1, "R7 inhibited swap");
        rd(BASE + 32, 2'd3, "R7 write had no effect");
        rd(BASE, 2'd3, "R7 swap had no effect");
        // R9
        req(3'd4, BASE, 2'd3, 64'h3333, '0, 1, 0, "R9 invalidate");
        rd(BASE, 2'd3, "R9 unchanged");
        // R10
        req(3'd1, BASE + 40, 2'd3, 64'h0BADC0DE, '0, 0, 0, "R10 silent write");
        rd(BASE + 40, 2'd3, "R10 write took effect");
        repeat (LAT + 4) @(negedge clk);
        check(q_data.size() == 0, "R8 all responses seen", 64'(q_data.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule